// File: doc/BRIEF.md
# Time-shared complex coefficient multiplier

This block carries out the frequency-domain half of a fast convolution. A stream of complex FFT bins arrives at the full processing rate, interleaved block by block across several branches. Each bin carries a branch tag and a bin index. One pipelined complex multiplier, built from three real multipliers, multiplies every bin by a stored complex coefficient and emits the product stream. The products leave in the order the bins arrived, so the natural order the following IFFT expects is kept.

The branch tag selects one of eight coefficient groups. The bin index selects one of 512 entries within that group. The coefficients sit in a dual-port store of 4096 complex words. One port serves the multiplier. The other port is a separate write port used to load new coefficient sets. Products are scaled by a fixed right shift, rounded, and saturated back to the input width. Valid, start-of-block, tag and bin index travel beside the data through a matched six-stage delay.

Top module: `tscm_top`

## Requirements
- R1: For an input bin (a + jb) and coefficient (c + jd), `out_re` equals round((a·c − b·d) / 2^SHIFT) and `out_im` equals round((a·d + b·c) / 2^SHIFT). Rounding adds 2^(SHIFT−1) and then takes the floor. SHIFT defaults to 15.
- R2: A scaled result above the largest value of the signed DATA_W range is output as 2^(DATA_W−1)−1. A result below the smallest value is output as −2^(DATA_W−1).
- R3: A bin accepted with `in_valid` high at a rising edge shows `out_valid` high right after the sixth rising edge, counting the capturing edge as the first. Bins may arrive on every cycle or with gaps of any length.
- R4: The coefficient used for a bin is the store word at address {in_tag, in_bin}. The 3-bit tag is the upper part and selects the group. The 9-bit bin index is the lower part and selects the entry.
- R5: `out_sob`, `out_tag` and `out_bin` equal the `in_sob`, `in_tag` and `in_bin` that entered with the same bin, delayed exactly as `out_valid` is.
- R6: In any cycle where `out_valid` is low, `out_re` and `out_im` are zero.
- R7: When `cw_en` is high at an edge, `{cw_re, cw_im}` is stored at `cw_addr`, which uses the same {group, bin} layout as R4. A bin read from that address at the same edge uses the previous word. A bin read at any later edge uses the new word.
- R8: While `rst` is high, and at the first edge after it falls, `out_valid` and `out_sob` are low and the data outputs are zero. Bins that were in flight when reset arrived are dropped.
- R9: A full 512-bin block fed in natural index order leaves in the same order, with no bin lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bin present |
| in_sob | input | 1 | First bin of a block |
| in_tag | input | 3 | Branch tag, selects the coefficient group |
| in_bin | input | 9 | Bin index within the block |
| in_re | input | DATA_W | Real part of the bin |
| in_im | input | DATA_W | Imaginary part of the bin |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | 12 | Coefficient write address {group, bin} |
| cw_re | input | COEF_W | Real part of the coefficient to write |
| cw_im | input | COEF_W | Imaginary part of the coefficient to write |
| out_valid | output | 1 | Product present |
| out_sob | output | 1 | Delayed start-of-block marker |
| out_tag | output | 3 | Delayed branch tag |
| out_bin | output | 9 | Delayed bin index |
| out_re | output | DATA_W | Real part of the product |
| out_im | output | DATA_W | Imaginary part of the product |

## Verification
The assertions assume that `in_sob` is raised only together with `in_valid`. They also assume that sideband inputs are stable from one falling edge to the next. The stimulus changes inputs only at falling edges and always drives the start marker together with a valid bin. The timing checks also assume a coefficient address is written before any valid bin reads it. The bench loads every group/bin pair it later streams before sending those bins, except in the deliberate same-edge write-and-read case of R7.

// File: rtl/tscm_pkg.sv
package tscm_pkg;

    // Coefficient addressing: group select in the upper bits, bin index below.
    localparam int GRP_W    = 3;
    localparam int BIN_W    = 9;
    localparam int ADDR_W   = GRP_W + BIN_W;
    localparam int DEPTH    = 1 << ADDR_W;

    // Fixed input-to-product latency in clock cycles.
    localparam int PIPE_LAT = 6;

    // Sideband that travels beside each bin through the pipeline.
    typedef struct packed {
        logic             vld;
        logic             sob;
        logic [GRP_W-1:0] tag;
        logic [BIN_W-1:0] bin;
    } side_t;

endpackage

// File: rtl/tscm_coef_ram.sv
module tscm_coef_ram #(
    parameter int WORD_W = 32,
    parameter int AW     = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [WORD_W-1:0] store [WORDS];

    // Write port: store the new word at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Read port: registered read. On a same-edge collision the old word is returned.
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end

endmodule

// File: rtl/tscm_side_dly.sv
module tscm_side_dly
    import tscm_pkg::*;
#(
    parameter int LAT = PIPE_LAT
) (
    input  logic  clk,
    input  logic  rst,
    input  side_t d,
    output side_t q,
    output logic  pre_vld
);

    side_t stage [LAT];

    genvar gi;
    generate
        for (gi = 0; gi < LAT; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[gi] <= '0;
                    else     stage[gi] <= d;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage[gi] <= '0;
                    else     stage[gi] <= stage[gi-1];
                end
            end
        end
    endgenerate

    assign q       = stage[LAT-1];
    assign pre_vld = stage[LAT-2].vld;

endmodule

// File: rtl/tscm_cmul3.sv
module tscm_cmul3 #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int SHIFT  = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     keep,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    input  logic signed [COEF_W-1:0] c,
    input  logic signed [COEF_W-1:0] d,
    output logic signed [DATA_W-1:0] y_re,
    output logic signed [DATA_W-1:0] y_im
);

    localparam int SA_W = DATA_W + 1;
    localparam int SC_W = COEF_W + 1;
    localparam int P1_W = DATA_W + COEF_W + 1;
    localparam int P_W  = P1_W + 1;
    localparam int R_W  = P_W + 1;

    localparam logic signed [R_W-1:0] HALF = R_W'(1) << (SHIFT - 1);
    localparam logic signed [R_W-1:0] MAXV = {{(R_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [R_W-1:0] MINV = {{(R_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    // Stage 2: pre-adders
    logic signed [SA_W-1:0]   sa;
    logic signed [SC_W-1:0]   dmc, cpd;
    logic signed [DATA_W-1:0] a2, b2;
    logic signed [COEF_W-1:0] c2;
    // Stage 3: three real products
    logic signed [P1_W-1:0]   k1, k2, k3;
    // Stage 4: post-adders
    logic signed [P_W-1:0]    re4, im4;
    // Stage 5: rounded and shifted
    logic signed [R_W-1:0]    re5, im5;

    function automatic logic signed [DATA_W-1:0] clip(input logic signed [R_W-1:0] v);
        if (v > MAXV)      clip = MAXV[DATA_W-1:0];
        else if (v < MINV) clip = MINV[DATA_W-1:0];
        else               clip = v[DATA_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            sa  <= '0;
            dmc <= '0;
            cpd <= '0;
            a2  <= '0;
            b2  <= '0;
            c2  <= '0;
        end else begin
            sa  <= SA_W'(a) + SA_W'(b);
            dmc <= SC_W'(d) - SC_W'(c);
            cpd <= SC_W'(c) + SC_W'(d);
            a2  <= a;
            b2  <= b;
            c2  <= c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k1 <= '0;
            k2 <= '0;
            k3 <= '0;
        end else begin
            k1 <= P1_W'(c2) * P1_W'(sa);
            k2 <= P1_W'(a2) * P1_W'(dmc);
            k3 <= P1_W'(b2) * P1_W'(cpd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            re4 <= '0;
            im4 <= '0;
        end else begin
            re4 <= P_W'(k1) - P_W'(k3);
            im4 <= P_W'(k1) + P_W'(k2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            re5 <= '0;
            im5 <= '0;
        end else begin
            re5 <= (R_W'(re4) + HALF) >>> SHIFT;
            im5 <= (R_W'(im4) + HALF) >>> SHIFT;
        end
    end

    // Stage 6: saturate; outputs held at zero for empty slots.
    always_ff @(posedge clk) begin
        if (rst || !keep) begin
            y_re <= '0;
            y_im <= '0;
        end else begin
            y_re <= clip(re5);
            y_im <= clip(im5);
        end
    end

endmodule

// File: rtl/tscm_top.sv
module tscm_top
    import tscm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int SHIFT  = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sob,
    input  logic [GRP_W-1:0]         in_tag,
    input  logic [BIN_W-1:0]         in_bin,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic                     cw_en,
    input  logic [ADDR_W-1:0]        cw_addr,
    input  logic signed [COEF_W-1:0] cw_re,
    input  logic signed [COEF_W-1:0] cw_im,
    output logic                     out_valid,
    output logic                     out_sob,
    output logic [GRP_W-1:0]         out_tag,
    output logic [BIN_W-1:0]         out_bin,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);

    localparam int WORD_W = 2 * COEF_W;

    side_t                     side_in, side_out;
    logic                      keep;
    logic [WORD_W-1:0]         coef_q;
    logic signed [DATA_W-1:0]  a1, b1;
    logic signed [COEF_W-1:0]  c1, d1;

    assign side_in = '{vld: in_valid, sob: in_sob, tag: in_tag, bin: in_bin};

    // Stage 1 data register, aligned with the registered coefficient read.
    always_ff @(posedge clk) begin
        if (rst) begin
            a1 <= '0;
            b1 <= '0;
        end else begin
            a1 <= in_re;
            b1 <= in_im;
        end
    end

    tscm_coef_ram #(
        .WORD_W (WORD_W),
        .AW     (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (cw_en),
        .waddr (cw_addr),
        .wdata ({cw_re, cw_im}),
        .raddr ({in_tag, in_bin}),
        .rdata (coef_q)
    );

    assign c1 = coef_q[WORD_W-1:COEF_W];
    assign d1 = coef_q[COEF_W-1:0];

    tscm_side_dly #(
        .LAT (PIPE_LAT)
    ) u_side (
        .clk     (clk),
        .rst     (rst),
        .d       (side_in),
        .q       (side_out),
        .pre_vld (keep)
    );

    tscm_cmul3 #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .SHIFT  (SHIFT)
    ) u_mul (
        .clk  (clk),
        .rst  (rst),
        .keep (keep),
        .a    (a1),
        .b    (b1),
        .c    (c1),
        .d    (d1),
        .y_re (out_re),
        .y_im (out_im)
    );

    assign out_valid = side_out.vld;
    assign out_sob   = side_out.sob;
    assign out_tag   = side_out.tag;
    assign out_bin   = side_out.bin;

endmodule

// File: rtl/tscm_chk.sv
module tscm_chk
    import tscm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sob,
    input logic [GRP_W-1:0]  in_tag,
    input logic [BIN_W-1:0]  in_bin,
    input logic              out_valid,
    input logic              out_sob,
    input logic [GRP_W-1:0]  out_tag,
    input logic [BIN_W-1:0]  out_bin,
    input logic [DATA_W-1:0] out_re,
    input logic [DATA_W-1:0] out_im
);

    logic [2:0] since_rst;
    logic       warm;
    logic       rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd6) since_rst <= since_rst + 3'd1;
    end

    assign warm = (since_rst == 3'd6);

    // R3
    latency_valid_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 6)));

    // R5
    side_align_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_bin == $past(in_bin, 6)
                               && out_tag == $past(in_tag, 6)
                               && out_sob == $past(in_sob, 6)));

    // R5
    sob_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_sob |-> out_valid);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_re == '0 && out_im == '0));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!out_valid && !out_sob));

endmodule

bind tscm_top tscm_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sob    (in_sob),
    .in_tag    (in_tag),
    .in_bin    (in_bin),
    .out_valid (out_valid),
    .out_sob   (out_sob),
    .out_tag   (out_tag),
    .out_bin   (out_bin),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/tb_tscm_top.sv
`timescale 1ns/1ps
module tb_tscm_top;
    import tscm_pkg::*;

    localparam int DW = 16;
    localparam int CW = 16;
    localparam int SH = 15;
    localparam int NL = 6;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_sob = 1'b0;
    logic [GRP_W-1:0]     in_tag = '0;
    logic [BIN_W-1:0]     in_bin = '0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 cw_en = 1'b0;
    logic [ADDR_W-1:0]    cw_addr = '0;
    logic signed [CW-1:0] cw_re = '0;
    logic signed [CW-1:0] cw_im = '0;
    logic                 out_valid, out_sob;
    logic [GRP_W-1:0]     out_tag;
    logic [BIN_W-1:0]     out_bin;
    logic signed [DW-1:0] out_re, out_im;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string req    = "R1";

    // Behavioural reference: coefficient store and a six-deep result queue.
    longint coef_re [DEPTH];
    longint coef_im [DEPTH];
    bit     m_v   [NL];
    bit     m_sob [NL];
    int     m_tag [NL];
    int     m_bin [NL];
    longint m_re  [NL];
    longint m_im  [NL];

    always #2.5 clk = ~clk;

    tscm_top #(.DATA_W(DW), .COEF_W(CW), .SHIFT(SH)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob),
        .in_tag(in_tag), .in_bin(in_bin), .in_re(in_re), .in_im(in_im),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_re(cw_re), .cw_im(cw_im),
        .out_valid(out_valid), .out_sob(out_sob), .out_tag(out_tag),
        .out_bin(out_bin), .out_re(out_re), .out_im(out_im)
    );

    function automatic longint scale(longint p);
        longint r;
        r = (p + (64'sd1 <<< (SH - 1))) >>> SH;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_v[i] = 0; m_sob[i] = 0; m_tag[i] = 0; m_bin[i] = 0; m_re[i] = 0; m_im[i] = 0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            coef_re[i] = 0; coef_im[i] = 0;
        end
    end

    always @(posedge clk) begin
        int     addr;
        longint a, b, c, d;
        addr = {in_tag, in_bin};
        a = longint'(in_re); b = longint'(in_im);
        c = coef_re[addr];   d = coef_im[addr];
        if (rst) begin
            for (int i = 0; i < NL; i++) begin
                m_v[i] = 0; m_sob[i] = 0; m_tag[i] = 0; m_bin[i] = 0; m_re[i] = 0; m_im[i] = 0;
            end
        end else begin
            for (int i = NL - 1; i > 0; i--) begin
                m_v[i] = m_v[i-1]; m_sob[i] = m_sob[i-1]; m_tag[i] = m_tag[i-1];
                m_bin[i] = m_bin[i-1]; m_re[i] = m_re[i-1]; m_im[i] = m_im[i-1];
            end
            m_v[0]   = in_valid;
            m_sob[0] = in_sob;
            m_tag[0] = int'(in_tag);
            m_bin[0] = int'(in_bin);
            m_re[0]  = scale(a * c - b * d);
            m_im[0]  = scale(a * d + b * c);
        end
        if (cw_en) begin
            coef_re[int'(cw_addr)] = longint'(cw_re);
            coef_im[int'(cw_addr)] = longint'(cw_im);
        end
    end

    task automatic chk(bit ok, string r, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(out_valid == m_v[NL-1], "R3", "out_valid", longint'(out_valid), longint'(m_v[NL-1]));
            if (m_v[NL-1]) begin
                chk(out_sob == m_sob[NL-1], "R5", "out_sob", longint'(out_sob), longint'(m_sob[NL-1]));
                chk(int'(out_tag) == m_tag[NL-1], "R5", "out_tag", longint'(out_tag), longint'(m_tag[NL-1]));
                chk(int'(out_bin) == m_bin[NL-1], "R5", "out_bin", longint'(out_bin), longint'(m_bin[NL-1]));
                chk(longint'(out_re) == m_re[NL-1], req, "out_re", longint'(out_re), m_re[NL-1]);
                chk(longint'(out_im) == m_im[NL-1], req, "out_im", longint'(out_im), m_im[NL-1]);
            end else begin
                chk(out_re == 0 && out_im == 0, "R6", "idle data", longint'(out_re), 0);
            end
        end
    end

    task automatic put_coef(int g, int bn, int re, int im);
        cw_en = 1'b1; cw_addr = ADDR_W'((g << BIN_W) | bn);
        cw_re = CW'(re); cw_im = CW'(im);
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic put_bin(bit v, bit s, int tg, int bn, int re, int im);
        in_valid = v; in_sob = s; in_tag = GRP_W'(tg); in_bin = BIN_W'(bn);
        in_re = DW'(re); in_im = DW'(im);
        @(negedge clk);
        in_valid = 1'b0; in_sob = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        checks++; fails++;
        $display("FAIL R3 watchdog: actual 100000 cycles expected completion");
        summary();
        $finish;
    end

    initial begin
        // R8: reset state
        idle(3);
        chk(!out_valid && !out_sob && out_re == 0 && out_im == 0, "R8", "reset outputs",
            longint'(out_valid), 0);
        rst = 1'b0;
        idle(2);

        // Load groups 0..7 bins 0..31, and the whole of group 5 (R4, R7 write port)
        for (int g = 0; g < 8; g++)
            for (int bn = 0; bn < 32; bn++)
                put_coef(g, bn, ((g * 4099 + bn * 733) % 60001) - 30000,
                                ((g * 2711 + bn * 1291) % 50003) - 25000);
        for (int bn = 32; bn < 512; bn++)
            put_coef(5, bn, ((bn * 911) % 64000) - 32000, ((bn * 457) % 60000) - 30000);
        idle(2);

        // R1 / R4: one block per branch, back to back
        req = "R4";
        for (int g = 0; g < 8; g++)
            for (int bn = 0; bn < 32; bn++)
                put_bin(1'b1, bn == 0, g, bn, int'($urandom_range(65535)) - 32768,
                        int'($urandom_range(65535)) - 32768);
        idle(8);

        // R3: gaps in the input stream
        req = "R1";
        for (int i = 0; i < 48; i++)
            put_bin(i % 3 != 0, i == 1, i % 8, (i * 5) % 32, i * 611 - 14000, 9000 - i * 377);
        idle(8);

        // R2: saturation in both directions
        req = "R2";
        put_coef(7, 100, -32768, -32768);
        put_coef(6, 101, 32767, 32767);
        idle(2);
        put_bin(1'b1, 1'b1, 7, 100, -32768, -32768);
        put_bin(1'b1, 1'b0, 6, 101, 32767, -32768);
        put_bin(1'b1, 1'b0, 6, 101, -32768, 32767);
        put_bin(1'b1, 1'b0, 6, 101, -32768, -32768);
        idle(8);

        // R7: write and read the same word on one edge, then read again
        req = "R7";
        cw_en = 1'b1; cw_addr = ADDR_W'((3 << BIN_W) | 7); cw_re = 16'sd12345; cw_im = -16'sd7000;
        put_bin(1'b1, 1'b1, 3, 7, 20000, -15000);
        cw_en = 1'b0;
        put_bin(1'b1, 1'b0, 3, 7, 20000, -15000);
        idle(8);

        // R9: full natural-order block on branch 5
        req = "R9";
        for (int bn = 0; bn < 512; bn++)
            put_bin(1'b1, bn == 0, 5, bn, (bn * 97) % 60000 - 30000, 16000 - bn * 61);
        idle(8);

        // R8: reset while the pipeline is full
        req = "R8";
        for (int bn = 0; bn < 4; bn++)
            put_bin(1'b1, bn == 0, 2, bn, 1000 * bn, -700 * bn);
        in_valid = 1'b1; rst = 1'b1;
        idle(1);
        chk(!out_valid && !out_sob, "R8", "in-reset valid", longint'(out_valid), 0);
        in_valid = 1'b0;
        idle(1);
        rst = 1'b0;
        idle(1);
        chk(!out_valid && out_re == 0 && out_im == 0, "R8", "after reset", longint'(out_valid), 0);
        idle(8);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule